// File: doc/BRIEF.md
# Pulse Interval Bit Decoder

The decoder sits behind the demodulator of a low-frequency contactless transponder. It watches a digitised reader field signal and a one-cycle carrier tick, and measures the number of carrier periods between successive rising edges of the field. Each measured interval becomes a '0' bit, a '1' bit, or nothing at all. The interval is dropped when it is too short, when it is too long, or when a silence ran past the end-of-frame limit just before it. Accepted bits are packed into a fixed-size frame buffer.

When the field shows no rising edge for longer than the end-of-frame limit, the frame is closed. If it holds at least one bit, the block issues a one-cycle strobe. At the same moment it presents the bit count and the packed bytes. It then empties the buffer for the next frame. The output is a plain strobe with no back-pressure. The consumer must act on the strobe, or read the outputs later, because they hold until the next strobe. The three interval thresholds are parameters in carrier periods.

Top module: `pulse_interval_decoder`

## Requirements
- R1: The interval counter advances only on cycles with `carrier_tick` high. A rising edge of `field_in` captures the count and restarts it. The restarted count is 1 if the edge cycle carries a tick, else 0. The counter saturates at `EOF_LIM`+1. A field period of N cycles with a tick on every cycle measures N.
- R2: An interval shorter than `ZERO_MIN` or longer than `EOF_LIM` yields no bit.
- R3: An interval from `ONE_MIN` to `EOF_LIM` inclusive is a '1'. An interval from `ZERO_MIN` to `ONE_MIN`-1 is a '0'. An edge that lands in the cycle where the count would reach the end-of-frame limit is still captured as a bit, and it does not close the frame.
- R4: Bit number p of a frame (counting from 0) is placed in byte p/8, bit 7-(p mod 8). Byte k occupies `frame_data[8k+7:8k]`.
- R5: The buffer holds 8×`FRAME_BYTES` bits (80 by default). Further bits are ignored, and the reported count never exceeds that capacity.
- R6: Once the count passes `EOF_LIM` with no edge, an overflow flag is set. The interval captured at the next edge yields no bit, and that edge clears the flag.
- R7: End of frame occurs on the tick that would move the count past `EOF_LIM` with no edge in that cycle. If at least one bit was received, `frame_valid` goes high for exactly one cycle, together with the count and the data. Otherwise no strobe is issued.
- R8: After end of frame the buffer and the bit position return to zero, so the next frame starts from an all-zero buffer.
- R9: `frame_bits` and `frame_data` hold their values between strobes, including while a new frame is being received and across an end of frame that held no bits.
- R10: A synchronous active-high `rst` clears the counter, the overflow flag, the bit position, the buffer and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| field_in | input | 1 | Digitised reader field, synchronous to clk |
| carrier_tick | input | 1 | One-cycle pulse per carrier period |
| frame_valid | output | 1 | One-cycle strobe at the close of a non-empty frame |
| frame_bits | output | $clog2(8*FRAME_BYTES+1) | Number of bits in the delivered frame |
| frame_data | output | 8*FRAME_BYTES | Packed frame bytes, byte k at [8k+7:8k] |

## Verification
A rising edge can arrive in the very cycle in which the carrier tick would push the count past the end-of-frame limit. Bit capture and frame closing then compete for the same cycle. The bench provokes this with an interval of exactly `EOF_LIM` ticks. The expected result is a single strobe after the following silence, carrying a count of one and a first byte of 0x80. That result shows the edge took priority and the frame did not close early. A separate test holds off the tick across a long quiet field. No frame may close during it, which confirms that only carrier periods advance the timeout.

// File: rtl/pid_pkg.sv
package pid_pkg;
  typedef enum logic [1:0] {
    SYM_DROP = 2'd0,
    SYM_ZERO = 2'd1,
    SYM_ONE  = 2'd2
  } sym_e;
endpackage

// File: rtl/pid_interval_timer.sv
module pid_interval_timer #(
  parameter int EOF_LIM = 20,
  parameter int CNT_W   = $clog2(EOF_LIM + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             field_in,
  input  logic             carrier_tick,
  output logic             edge_seen,
  output logic [CNT_W-1:0] run_cnt,
  output logic             meas_ovf,
  output logic             eof_hit
);
  localparam logic [CNT_W-1:0] EOF_C = CNT_W'(EOF_LIM);
  localparam logic [CNT_W-1:0] SAT_C = CNT_W'(EOF_LIM + 1);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic field_q;
  logic [CNT_W-1:0] cnt_q;
  logic ovf_q;

  // rising edge of the field, seen in the cycle the input first reads high
  assign edge_seen = field_in & ~field_q;
  // timeout: a tick would carry the count past the limit and no edge competes
  assign eof_hit   = carrier_tick & ~edge_seen & (cnt_q == EOF_C);
  assign run_cnt   = cnt_q;
  assign meas_ovf  = ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      field_q <= 1'b0;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      field_q <= field_in;
      if (edge_seen) begin
        cnt_q <= carrier_tick ? ONE_C : '0;
      end else if (carrier_tick && (cnt_q != SAT_C)) begin
        cnt_q <= cnt_q + ONE_C;
      end
      if (edge_seen) begin
        ovf_q <= 1'b0;
      end else if (eof_hit) begin
        ovf_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pid_classifier.sv
module pid_classifier
  import pid_pkg::*;
#(
  parameter int ZERO_MIN = 6,
  parameter int ONE_MIN  = 12,
  parameter int EOF_LIM  = 20,
  parameter int CNT_W    = $clog2(EOF_LIM + 2)
) (
  input  logic [CNT_W-1:0] len,
  input  logic             ovf,
  output sym_e             sym
);
  localparam logic [CNT_W-1:0] ZERO_C = CNT_W'(ZERO_MIN);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(ONE_MIN);
  localparam logic [CNT_W-1:0] EOF_C  = CNT_W'(EOF_LIM);

  always_comb begin
    if (ovf || (len > EOF_C) || (len < ZERO_C)) begin
      sym = SYM_DROP;
    end else if (len >= ONE_C) begin
      sym = SYM_ONE;
    end else begin
      sym = SYM_ZERO;
    end
  end
endmodule

// File: rtl/pid_frame_packer.sv
module pid_frame_packer #(
  parameter int FRAME_BYTES = 10,
  parameter int NBITS       = 8 * FRAME_BYTES,
  parameter int POS_W       = $clog2(NBITS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_vld,
  input  logic             bit_val,
  input  logic             eof_hit,
  output logic             frame_valid,
  output logic [POS_W-1:0] frame_bits,
  output logic [NBITS-1:0] frame_data,
  output logic [POS_W-1:0] bit_pos
);
  localparam logic [POS_W-1:0] FULL_C = POS_W'(NBITS);
  localparam logic [POS_W-1:0] STEP_C = POS_W'(1);

  logic [NBITS-1:0] frame_q;
  logic [NBITS-1:0] wr_mask;
  logic [POS_W-1:0] pos_q;
  logic             room;

  // one write-enable per buffer position, most significant bit of each byte first
  for (genvar p = 0; p < NBITS; p++) begin : g_pos
    assign wr_mask[(p / 8) * 8 + 7 - (p % 8)] = (pos_q == POS_W'(p));
  end

  assign room    = (pos_q != FULL_C);
  assign bit_pos = pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q     <= '0;
      pos_q       <= '0;
      frame_valid <= 1'b0;
      frame_bits  <= '0;
      frame_data  <= '0;
    end else begin
      frame_valid <= 1'b0;
      if (eof_hit) begin
        if (pos_q != '0) begin
          frame_valid <= 1'b1;
          frame_bits  <= pos_q;
          frame_data  <= frame_q;
        end
        frame_q <= '0;
        pos_q   <= '0;
      end else if (bit_vld && room) begin
        frame_q <= (frame_q & ~wr_mask) | (bit_val ? wr_mask : '0);
        pos_q   <= pos_q + STEP_C;
      end
    end
  end
endmodule

// File: rtl/pulse_interval_decoder.sv
module pulse_interval_decoder
  import pid_pkg::*;
#(
  parameter int FRAME_BYTES = 10,
  parameter int ZERO_MIN    = 6,
  parameter int ONE_MIN     = 12,
  parameter int EOF_LIM     = 20
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 field_in,
  input  logic                                 carrier_tick,
  output logic                                 frame_valid,
  output logic [$clog2(8*FRAME_BYTES+1)-1:0]   frame_bits,
  output logic [8*FRAME_BYTES-1:0]             frame_data
);
  localparam int NBITS = 8 * FRAME_BYTES;
  localparam int POS_W = $clog2(NBITS + 1);
  localparam int CNT_W = $clog2(EOF_LIM + 2);

  logic             edge_seen;
  logic [CNT_W-1:0] run_cnt;
  logic             meas_ovf;
  logic             eof_hit;
  sym_e             sym;
  logic             bit_vld;
  logic             bit_val;
  logic [POS_W-1:0] bit_pos;

  pid_interval_timer #(
    .EOF_LIM (EOF_LIM),
    .CNT_W   (CNT_W)
  ) timer_i (
    .clk          (clk),
    .rst          (rst),
    .field_in     (field_in),
    .carrier_tick (carrier_tick),
    .edge_seen    (edge_seen),
    .run_cnt      (run_cnt),
    .meas_ovf     (meas_ovf),
    .eof_hit      (eof_hit)
  );

  pid_classifier #(
    .ZERO_MIN (ZERO_MIN),
    .ONE_MIN  (ONE_MIN),
    .EOF_LIM  (EOF_LIM),
    .CNT_W    (CNT_W)
  ) class_i (
    .len (run_cnt),
    .ovf (meas_ovf),
    .sym (sym)
  );

  assign bit_vld = edge_seen && (sym != SYM_DROP);
  assign bit_val = (sym == SYM_ONE);

  pid_frame_packer #(
    .FRAME_BYTES (FRAME_BYTES),
    .NBITS       (NBITS),
    .POS_W       (POS_W)
  ) pack_i (
    .clk         (clk),
    .rst         (rst),
    .bit_vld     (bit_vld),
    .bit_val     (bit_val),
    .eof_hit     (eof_hit),
    .frame_valid (frame_valid),
    .frame_bits  (frame_bits),
    .frame_data  (frame_data),
    .bit_pos     (bit_pos)
  );
endmodule

// File: rtl/pid_checker.sv
module pid_checker #(
  parameter int NBITS   = 80,
  parameter int EOF_LIM = 20,
  parameter int POS_W   = 7,
  parameter int CNT_W   = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             edge_seen,
  input logic [CNT_W-1:0] run_cnt,
  input logic             meas_ovf,
  input logic             eof_hit,
  input logic             bit_vld,
  input logic [POS_W-1:0] bit_pos,
  input logic             frame_valid,
  input logic [POS_W-1:0] frame_bits,
  input logic [NBITS-1:0] frame_data
);
  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
    int'(run_cnt) <= EOF_LIM + 1); // R1

  AST_EDGE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    edge_seen |=> int'(run_cnt) <= 1); // R1

  AST_OVF_DROPS_BIT: assert property (@(posedge clk) disable iff (rst)
    (edge_seen && meas_ovf) |-> !bit_vld); // R6

  AST_POS_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    int'(bit_pos) <= NBITS); // R5

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> (frame_bits != '0) && (int'(frame_bits) <= NBITS)); // R5

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid); // R7

  AST_EOF_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    eof_hit |=> bit_pos == '0); // R8

  AST_OUTPUT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!frame_valid && !$past(rst)) |-> ($stable(frame_bits) && $stable(frame_data))); // R9
endmodule

bind pulse_interval_decoder pid_checker #(
  .NBITS   (NBITS),
  .EOF_LIM (EOF_LIM),
  .POS_W   (POS_W),
  .CNT_W   (CNT_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .edge_seen   (edge_seen),
  .run_cnt     (run_cnt),
  .meas_ovf    (meas_ovf),
  .eof_hit     (eof_hit),
  .bit_vld     (bit_vld),
  .bit_pos     (bit_pos),
  .frame_valid (frame_valid),
  .frame_bits  (frame_bits),
  .frame_data  (frame_data)
);

// File: tb/pulse_interval_decoder_tb_top.sv
`timescale 1ns/1ps
module pulse_interval_decoder_tb_top;
  localparam int CLK_PERIOD  = 10;
  localparam int FRAME_BYTES = 10;
  localparam int NBITS       = 8 * FRAME_BYTES;
  localparam int POS_W       = $clog2(NBITS + 1);
  localparam int ZERO_MIN    = 6;
  localparam int ONE_MIN     = 12;
  localparam int EOF_LIM     = 20;

  // interval lengths and expected symbol: 0 = '0', 1 = '1', 2 = dropped
  localparam int VEC_N = 12;
  localparam int VEC_LEN [VEC_N] = '{6, 12, 5, 11, 20, 7, 3, 13, 19, 6, 12, 15};
  localparam int VEC_SYM [VEC_N] = '{0,  1, 2,  0,  1, 0, 2,  1,  1, 0,  1,  1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic field_in = 1'b0;
  logic carrier_tick = 1'b1;
  logic             frame_valid;
  logic [POS_W-1:0] frame_bits;
  logic [NBITS-1:0] frame_data;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  logic [POS_W-1:0] cap_bits = '0;
  logic [NBITS-1:0] cap_data = '0;
  logic [NBITS-1:0] exp_data;
  int exp_pos;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pulse_interval_decoder #(
    .FRAME_BYTES (FRAME_BYTES),
    .ZERO_MIN    (ZERO_MIN),
    .ONE_MIN     (ONE_MIN),
    .EOF_LIM     (EOF_LIM)
  ) dut_i (
    .clk          (clk),
    .rst          (rst),
    .field_in     (field_in),
    .carrier_tick (carrier_tick),
    .frame_valid  (frame_valid),
    .frame_bits   (frame_bits),
    .frame_data   (frame_data)
  );

  always begin
    @(negedge clk);
    #1;
    if (frame_valid === 1'b1) begin
      pulses++;
      cap_bits = frame_bits;
      cap_data = frame_data;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    exp_data = '0;
    exp_pos  = 0;
  endtask

  task automatic model_push(input int code);
    if (code != 2 && exp_pos < NBITS) begin
      exp_data[(exp_pos / 8) * 8 + 7 - (exp_pos % 8)] = (code == 1);
      exp_pos++;
    end
  endtask

  task automatic silence(input int n);
    field_in = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // rising edge now, next rising edge len cycles later
  task automatic edge_after(input int len);
    field_in = 1'b1;
    @(negedge clk);
    field_in = 1'b0;
    repeat (len - 1) @(negedge clk);
  endtask

  task automatic close_frame();
    field_in = 1'b1;
    @(negedge clk);
    silence(EOF_LIM + 6);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int base;
    logic [NBITS-1:0] keep_data;
    repeat (3) @(negedge clk);
    check("R10", "strobe in reset", 128'(frame_valid), 128'(0));
    check("R10", "count in reset", 128'(frame_bits), 128'(0));
    check("R10", "data in reset", 128'(frame_data), 128'(0));
    rst = 1'b0;
    silence(EOF_LIM + 5);

    // vector table: one frame built from every entry
    model_clear();
    base = pulses;
    for (int i = 0; i < VEC_N; i++) begin
      edge_after(VEC_LEN[i]);
      model_push(VEC_SYM[i]);
    end
    close_frame();
    check("R7", "strobes for table frame", 128'(pulses - base), 128'(1));
    check("R3", "count with R2 drops", 128'(cap_bits), 128'(exp_pos));
    check("R4", "packed table frame", 128'(cap_data), 128'(exp_data));
    keep_data = exp_data;

    // R9: outputs hold while the next frame is being received
    edge_after(12);
    edge_after(12);
    edge_after(12);
    check("R9", "data held mid-frame", 128'(frame_data), 128'(keep_data));
    check("R9", "count held mid-frame", 128'(frame_bits), 128'(10));
    close_frame();
    check("R3", "three ones data", 128'(cap_data), 128'(8'hE0));

    // R2 and R7: frame of only dropped intervals gives no strobe
    base = pulses;
    edge_after(3);
    edge_after(5);
    close_frame();
    check("R7", "no strobe for empty frame", 128'(pulses - base), 128'(0));
    check("R9", "count kept after empty frame", 128'(frame_bits), 128'(3));

    // R6: a lone edge after overflow yields nothing
    base = pulses;
    close_frame();
    check("R6", "edge after overflow dropped", 128'(pulses - base), 128'(0));

    // R5: overfill the buffer
    model_clear();
    base = pulses;
    for (int i = 0; i < NBITS + 5; i++) begin
      edge_after((i % 3 == 0) ? 14 : 8);
      model_push((i % 3 == 0) ? 1 : 0);
    end
    close_frame();
    check("R5", "count capped", 128'(cap_bits), 128'(NBITS));
    check("R5", "full frame data", 128'(cap_data), 128'(exp_data));

    // R8: next frame starts from an empty buffer
    edge_after(6);
    edge_after(6);
    edge_after(6);
    close_frame();
    check("R8", "three zeros after full frame", 128'(cap_data), 128'(0));
    check("R8", "count restarts", 128'(cap_bits), 128'(3));

    // R3: edge in the same cycle as the timeout
    base = pulses;
    edge_after(EOF_LIM);
    close_frame();
    check("R3", "limit interval strobes once", 128'(pulses - base), 128'(1));
    check("R3", "limit interval is one", 128'(cap_data), 128'(8'h80));
    check("R3", "limit interval count", 128'(cap_bits), 128'(1));

    // R1: no ticks, no timeout
    base = pulses;
    edge_after(12);
    edge_after(6);
    field_in = 1'b1;
    @(negedge clk);
    field_in = 1'b0;
    carrier_tick = 1'b0;
    silence(100);
    check("R1", "no close without ticks", 128'(pulses - base), 128'(0));
    carrier_tick = 1'b1;
    silence(EOF_LIM + 6);
    check("R1", "close after ticks resume", 128'(pulses - base), 128'(1));
    check("R1", "one then zero", 128'(cap_data), 128'(8'h80));

    // R10: reset mid-frame discards collected bits
    base = pulses;
    edge_after(12);
    edge_after(12);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    close_frame();
    check("R10", "no strobe after reset", 128'(pulses - base), 128'(0));
    check("R10", "count cleared", 128'(frame_bits), 128'(0));
    check("R10", "data cleared", 128'(frame_data), 128'(0));

    finish_run();
  end
endmodule